// File: doc/BRIEF.md
# Sequencer CPU Instruction Decoder

This block decodes the 27-bit instruction word of a small 16-bit CPU that sequences hash computations. It splits each word into its operand fields and sorts the 5-bit opcode into control classes. The classes cover register writes, register reads, byte-feeding commands, context setup, memory-to-register moves, jumps and halts. It also reports which flags the instruction updates or consumes. It checks whether an instruction that is tied to thread state may issue under the thread state sampled with it. An opcode that is not defined decodes as a no-operation and raises an illegal marker.

Instruction words arrive on a valid/ready stream, and decoded words leave on a second valid/ready stream after one register stage. The input takes a word whenever the output stage is empty or is being emptied in the same cycle. While the downstream side holds `out_ready` low, the decoded word stays frozen and the input is back-pressured. The thread state is a plain control input and is captured together with the word. The parameter `CARRY_OPS_EN` removes the two carry-consuming arithmetic opcodes, which then decode as illegal.

Top module: `hseq_decode`

## Requirements
- R1: The word splits as bits [26:23] read register index, [22] thread-gated option bit, [21:18] condition, [17:13] field B, [12:5] 8-bit constant, [4:0] opcode. The first five appear unchanged on the outputs for every opcode.
- R2: A word accepted while `in_valid` and `in_ready` are both 1 appears on the outputs in the next cycle with `out_valid` 1. `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is 1 and `out_ready` is 0, every output holds.
- R3: Byte-feeding commands are opcodes 8, 9, 10, 12, 13 and 14. Of these, 12, 13 and 14 take their count from a register. The stop forms are 9 and 13, and the context-finishing forms are 10 and 14.
- R4: Opcodes 6 and 7 initialise a context, and only 7 starts a fresh one. Opcode 31 is a jump with its target in the constant field. Opcode 1 is a halt.
- R5: The register-writing opcodes are 16 through 24.
- R6: The register-reading opcodes are 16 through 24 except 21, together with 12, 14 and 26.
- R7: The zero flag is updated by 18, 20 and 22. The one flag is updated only by 22. Carry is updated by 16, 17, 18 and 19, and carry is consumed only by 17 and 19.
- R8: Opcodes 28, 29 and 30 are memory-to-register moves.
- R9: The need-write-ready output equals the option bit. The issue-permitted output is 1 when the option bit is 0 or when the thread state captured with the word equals 1 (write-ready). The other states are none = 0, read-ready = 2 and busy = 3.
- R10: Opcodes 2, 3, 4, 5, 11, 15, 25 and 27 are undefined. For these the decoder sets the illegal output, drives opcode 0 and clears every class and flag output.
- R11: With `CARRY_OPS_EN` = 0, opcodes 17 and 19 decode as undefined under R10.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 27 | Instruction word |
| thread_state | input | 2 | Thread state captured with the word |
| out_valid | output | 1 | Decoded word present |
| out_ready | input | 1 | Downstream takes the decoded word |
| dec_rd_idx | output | 4 | Read register index |
| dec_opt | output | 1 | Thread-gated option bit |
| dec_cond | output | 4 | Condition code |
| dec_field_b | output | 5 | Field B |
| dec_const | output | 8 | Constant field |
| dec_opcode | output | 5 | Effective opcode (0 when illegal) |
| dec_writes_reg | output | 1 | Writes a register |
| dec_reads_reg | output | 1 | Reads a register |
| dec_bytes_cmd | output | 1 | Byte-feeding command |
| dec_bytes_from_reg | output | 1 | Byte count from a register |
| dec_bytes_stop | output | 1 | Stop form |
| dec_bytes_finish | output | 1 | Context-finishing form |
| dec_ctx_init | output | 1 | Context initialisation |
| dec_ctx_fresh | output | 1 | Fresh context |
| dec_mem_move | output | 1 | Memory-to-register move |
| dec_jump | output | 1 | Jump |
| dec_halt | output | 1 | Halt |
| dec_upd_zero | output | 1 | Updates zero flag |
| dec_upd_one | output | 1 | Updates one flag |
| dec_upd_carry | output | 1 | Updates carry flag |
| dec_use_carry | output | 1 | Consumes carry flag |
| dec_need_wr_ready | output | 1 | Needs write-ready thread state |
| dec_issue_ok | output | 1 | Issue permitted under captured state |
| dec_illegal | output | 1 | Undefined opcode |

## Verification
A word can be taken in the same cycle that the previous decoded word is being drained. This happens only when `out_valid` and `out_ready` are both 1. The bench runs long back-to-back streams with `out_ready` held high, and mixes these with streams that pulse `out_ready` at random. The reference model pops the old word and pushes the new one in that same cycle, so a loss or duplication at the handover shows up as a field mismatch. Stalled cycles compare the frozen head entry again on every clock. Two instances, one with the carry opcodes enabled and one with them disabled, see the same stream, including every opcode under all four thread states.

// File: rtl/hseq_dec_pkg.sv
package hseq_dec_pkg;
  localparam int IDX_W   = 4;
  localparam int COND_W  = 4;
  localparam int FB_W    = 5;
  localparam int FC_W    = 8;
  localparam int OP_W    = 5;
  localparam int TS_W    = 2;
  localparam int WORD_W  = IDX_W + 1 + COND_W + FB_W + FC_W + OP_W;

  typedef enum logic [TS_W-1:0] {
    TS_IDLE  = 2'd0,
    TS_WRRDY = 2'd1,
    TS_RDRDY = 2'd2,
    TS_BUSY  = 2'd3
  } tstate_e;

  typedef struct packed {
    logic [IDX_W-1:0]  rd_idx;
    logic              opt;
    logic [COND_W-1:0] cond;
    logic [FB_W-1:0]   fb;
    logic [FC_W-1:0]   fc;
    logic [OP_W-1:0]   op;
  } fields_t;

  typedef struct packed {
    logic wr_reg;
    logic rd_reg;
    logic bytes;
    logic bytes_reg;
    logic bytes_stop;
    logic bytes_fin;
    logic ctx_init;
    logic ctx_fresh;
    logic mem_mv;
    logic jump;
    logic halt;
    logic upd_z;
    logic upd_one;
    logic upd_c;
    logic use_c;
  } class_t;

  typedef struct packed {
    fields_t f;
    class_t  c;
    logic    need_wr;
    logic    issue_ok;
    logic    illegal;
  } dec_t;
endpackage

// File: rtl/hseq_dec_fields.sv
module hseq_dec_fields
  import hseq_dec_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output fields_t           fields
);
  localparam int OP_LO   = 0;
  localparam int FC_LO   = OP_LO + OP_W;
  localparam int FB_LO   = FC_LO + FC_W;
  localparam int COND_LO = FB_LO + FB_W;
  localparam int OPT_POS = COND_LO + COND_W;
  localparam int IDX_LO  = OPT_POS + 1;

  assign fields.op     = word[OP_LO   +: OP_W];
  assign fields.fc     = word[FC_LO   +: FC_W];
  assign fields.fb     = word[FB_LO   +: FB_W];
  assign fields.cond   = word[COND_LO +: COND_W];
  assign fields.opt    = word[OPT_POS];
  assign fields.rd_idx = word[IDX_LO  +: IDX_W];
endmodule

// File: rtl/hseq_dec_classify.sv
module hseq_dec_classify
  import hseq_dec_pkg::*;
#(
  parameter bit CARRY_OPS_EN = 1'b1
) (
  input  logic [OP_W-1:0] op_in,
  output logic [OP_W-1:0] op_out,
  output class_t          cls,
  output logic            illegal
);
  logic carry_ok;
  logic known;

  generate
    if (CARRY_OPS_EN) begin : g_carry_on
      assign carry_ok = 1'b1;
    end else begin : g_carry_off
      assign carry_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    case (op_in) inside
      5'd0, 5'd1, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10,
      5'd12, 5'd13, 5'd14, [5'd16:5'd24], 5'd26,
      [5'd28:5'd31]: known = 1'b1;
      default:       known = 1'b0;
    endcase
    if ((op_in == 5'd17 || op_in == 5'd19) && !carry_ok) known = 1'b0;
  end

  always_comb begin
    cls     = '0;
    illegal = !known;
    op_out  = known ? op_in : '0;
    if (known) begin
      cls.wr_reg     = op_in inside {[5'd16:5'd24]};
      cls.rd_reg     = (cls.wr_reg && op_in != 5'd21) ||
                       op_in inside {5'd12, 5'd14, 5'd26};
      cls.bytes      = op_in inside {[5'd8:5'd15]};
      cls.bytes_reg  = op_in inside {[5'd12:5'd15]};
      cls.bytes_stop = op_in inside {5'd9, 5'd13};
      cls.bytes_fin  = op_in inside {5'd10, 5'd14};
      cls.ctx_init   = op_in inside {5'd6, 5'd7};
      cls.ctx_fresh  = op_in == 5'd7;
      cls.mem_mv     = op_in inside {[5'd28:5'd30]};
      cls.jump       = op_in == 5'd31;
      cls.halt       = op_in == 5'd1;
      cls.upd_z      = op_in inside {5'd18, 5'd20, 5'd22};
      cls.upd_one    = op_in == 5'd22;
      cls.upd_c      = op_in inside {[5'd16:5'd19]};
      cls.use_c      = op_in inside {5'd17, 5'd19};
    end
  end
endmodule

// File: rtl/hseq_pipe_reg.sv
module hseq_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/hseq_decode.sv
module hseq_decode
  import hseq_dec_pkg::*;
#(
  parameter bit CARRY_OPS_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [TS_W-1:0]   thread_state,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  dec_rd_idx,
  output logic              dec_opt,
  output logic [COND_W-1:0] dec_cond,
  output logic [FB_W-1:0]   dec_field_b,
  output logic [FC_W-1:0]   dec_const,
  output logic [OP_W-1:0]   dec_opcode,
  output logic              dec_writes_reg,
  output logic              dec_reads_reg,
  output logic              dec_bytes_cmd,
  output logic              dec_bytes_from_reg,
  output logic              dec_bytes_stop,
  output logic              dec_bytes_finish,
  output logic              dec_ctx_init,
  output logic              dec_ctx_fresh,
  output logic              dec_mem_move,
  output logic              dec_jump,
  output logic              dec_halt,
  output logic              dec_upd_zero,
  output logic              dec_upd_one,
  output logic              dec_upd_carry,
  output logic              dec_use_carry,
  output logic              dec_need_wr_ready,
  output logic              dec_issue_ok,
  output logic              dec_illegal
);
  localparam int DW = $bits(dec_t);

  fields_t raw;
  class_t  cls;
  logic    ill;
  logic [OP_W-1:0] op_eff;
  dec_t    nxt;
  dec_t    cur;
  logic [DW-1:0] cur_vec;

  hseq_dec_fields u_fields (
    .word   (in_word),
    .fields (raw)
  );

  hseq_dec_classify #(.CARRY_OPS_EN(CARRY_OPS_EN)) u_class (
    .op_in   (raw.op),
    .op_out  (op_eff),
    .cls     (cls),
    .illegal (ill)
  );

  always_comb begin
    nxt          = '0;
    nxt.f        = raw;
    nxt.f.op     = op_eff;
    nxt.c        = cls;
    nxt.illegal  = ill;
    nxt.need_wr  = raw.opt;
    nxt.issue_ok = !raw.opt || (tstate_e'(thread_state) == TS_WRRDY);
  end

  hseq_pipe_reg #(.W(DW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (nxt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (cur_vec)
  );

  assign cur                = dec_t'(cur_vec);
  assign dec_rd_idx         = cur.f.rd_idx;
  assign dec_opt            = cur.f.opt;
  assign dec_cond           = cur.f.cond;
  assign dec_field_b        = cur.f.fb;
  assign dec_const          = cur.f.fc;
  assign dec_opcode         = cur.f.op;
  assign dec_writes_reg     = cur.c.wr_reg;
  assign dec_reads_reg      = cur.c.rd_reg;
  assign dec_bytes_cmd      = cur.c.bytes;
  assign dec_bytes_from_reg = cur.c.bytes_reg;
  assign dec_bytes_stop     = cur.c.bytes_stop;
  assign dec_bytes_finish   = cur.c.bytes_fin;
  assign dec_ctx_init       = cur.c.ctx_init;
  assign dec_ctx_fresh      = cur.c.ctx_fresh;
  assign dec_mem_move       = cur.c.mem_mv;
  assign dec_jump           = cur.c.jump;
  assign dec_halt           = cur.c.halt;
  assign dec_upd_zero       = cur.c.upd_z;
  assign dec_upd_one        = cur.c.upd_one;
  assign dec_upd_carry      = cur.c.upd_c;
  assign dec_use_carry      = cur.c.use_c;
  assign dec_need_wr_ready  = cur.need_wr;
  assign dec_issue_ok       = cur.issue_ok;
  assign dec_illegal        = cur.illegal;

  // R2: a stalled output word must not change
  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(cur_vec));

  // R9: an instruction without the option bit is always permitted
  assert_issue_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !dec_opt |-> dec_issue_ok);

  // R10: illegal words look like a no-operation
  assert_illegal_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && dec_illegal |-> dec_opcode == '0 && !dec_writes_reg &&
      !dec_reads_reg && !dec_bytes_cmd && !dec_ctx_init && !dec_mem_move &&
      !dec_jump && !dec_halt && !dec_upd_carry && !dec_upd_zero);

  // R6: every writer except the constant move also reads
  assert_writer_reads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && dec_writes_reg && dec_opcode != 5'd21 |-> dec_reads_reg);

  // R3: register-count forms are byte-feeding commands
  assert_bytes_reg_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && dec_bytes_from_reg |-> dec_bytes_cmd);

  // R11: with carry ops removed, nothing consumes carry
  assert_no_carry_use_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && dec_use_carry |-> CARRY_OPS_EN);
endmodule

// File: tb/hseq_decode_tb.sv
module hseq_decode_tb;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [3:0] a;
    logic       x;
    logic [3:0] cond;
    logic [4:0] b;
    logic [7:0] c;
    logic [4:0] op;
    logic wr, rd, by, byr, bst, bfi, ci, cnew, mem, jmp, hlt, zf, of, cfu, cfc;
    logic need, iss, ill;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [26:0] in_word = '0;
  logic [1:0]  tstate = '0;
  logic        out_ready = 1'b0;
  logic        rdy0, rdy1, ov0, ov1;
  wire exp_t   g0;
  wire exp_t   g1;
  int          errors = 0;
  int          checks = 0;
  exp_t        q0[$];
  exp_t        q1[$];

  always #(CLK_P/2) clk = ~clk;

  hseq_decode #(.CARRY_OPS_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0),
    .in_word(in_word), .thread_state(tstate), .out_valid(ov0), .out_ready(out_ready),
    .dec_rd_idx(g0.a), .dec_opt(g0.x), .dec_cond(g0.cond), .dec_field_b(g0.b),
    .dec_const(g0.c), .dec_opcode(g0.op), .dec_writes_reg(g0.wr), .dec_reads_reg(g0.rd),
    .dec_bytes_cmd(g0.by), .dec_bytes_from_reg(g0.byr), .dec_bytes_stop(g0.bst),
    .dec_bytes_finish(g0.bfi), .dec_ctx_init(g0.ci), .dec_ctx_fresh(g0.cnew),
    .dec_mem_move(g0.mem), .dec_jump(g0.jmp), .dec_halt(g0.hlt), .dec_upd_zero(g0.zf),
    .dec_upd_one(g0.of), .dec_upd_carry(g0.cfu), .dec_use_carry(g0.cfc),
    .dec_need_wr_ready(g0.need), .dec_issue_ok(g0.iss), .dec_illegal(g0.ill));

  hseq_decode #(.CARRY_OPS_EN(1'b0)) u_dut_nc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1),
    .in_word(in_word), .thread_state(tstate), .out_valid(ov1), .out_ready(out_ready),
    .dec_rd_idx(g1.a), .dec_opt(g1.x), .dec_cond(g1.cond), .dec_field_b(g1.b),
    .dec_const(g1.c), .dec_opcode(g1.op), .dec_writes_reg(g1.wr), .dec_reads_reg(g1.rd),
    .dec_bytes_cmd(g1.by), .dec_bytes_from_reg(g1.byr), .dec_bytes_stop(g1.bst),
    .dec_bytes_finish(g1.bfi), .dec_ctx_init(g1.ci), .dec_ctx_fresh(g1.cnew),
    .dec_mem_move(g1.mem), .dec_jump(g1.jmp), .dec_halt(g1.hlt), .dec_upd_zero(g1.zf),
    .dec_upd_one(g1.of), .dec_upd_carry(g1.cfu), .dec_use_carry(g1.cfc),
    .dec_need_wr_ready(g1.need), .dec_issue_ok(g1.iss), .dec_illegal(g1.ill));

  function automatic exp_t model(logic [26:0] w, logic [1:0] ts, bit carry_en);
    exp_t e;
    int   o;
    bit   ok;
    e = '0;
    o = int'(w[4:0]);
    e.a = w[26:23]; e.x = w[22]; e.cond = w[21:18]; e.b = w[17:13]; e.c = w[12:5];
    ok = !(o inside {2, 3, 4, 5, 11, 15, 25, 27});
    if (!carry_en && (o == 17 || o == 19)) ok = 0;
    e.need = w[22];
    e.iss  = (w[22] == 1'b0) || (ts == 2'd1);
    e.ill  = !ok;
    if (ok) begin
      e.op   = w[4:0];
      e.wr   = (o >= 16 && o <= 24);
      e.rd   = (e.wr && o != 21) || o == 12 || o == 14 || o == 26;
      e.by   = o inside {8, 9, 10, 12, 13, 14};
      e.byr  = o inside {12, 13, 14};
      e.bst  = o inside {9, 13};
      e.bfi  = o inside {10, 14};
      e.ci   = o inside {6, 7};
      e.cnew = (o == 7);
      e.mem  = o inside {28, 29, 30};
      e.jmp  = (o == 31);
      e.hlt  = (o == 1);
      e.zf   = o inside {18, 20, 22};
      e.of   = (o == 22);
      e.cfu  = o inside {16, 17, 18, 19};
      e.cfc  = o inside {17, 19};
    end
    return e;
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cmp(exp_t g, exp_t e, bit nc);
    chk("R1 fields", int'({g.a, g.x, g.cond, g.b, g.c}), int'({e.a, e.x, e.cond, e.b, e.c}));
    chk(nc ? "R11 opcode/illegal" : "R10 opcode/illegal", int'({g.op, g.ill}), int'({e.op, e.ill}));
    chk("R3 bytes", int'({g.by, g.byr, g.bst, g.bfi}), int'({e.by, e.byr, e.bst, e.bfi}));
    chk("R4 ctx/jump/halt", int'({g.ci, g.cnew, g.jmp, g.hlt}), int'({e.ci, e.cnew, e.jmp, e.hlt}));
    chk("R5 writes", int'(g.wr), int'(e.wr));
    chk("R6 reads", int'(g.rd), int'(e.rd));
    chk(nc ? "R11 flags" : "R7 flags", int'({g.zf, g.of, g.cfu, g.cfc}), int'({e.zf, e.of, e.cfu, e.cfc}));
    chk("R8 mem move", int'(g.mem), int'(e.mem));
    chk("R9 gating", int'({g.need, g.iss}), int'({e.need, e.iss}));
  endtask

  // one cycle: compare state after the last edge, then drive and book the next edge
  task automatic step(bit v, logic [26:0] w, logic [1:0] ts, bit ordy);
    @(negedge clk);
    chk("R2 valid u_dut", int'(ov0), int'(q0.size() != 0));
    chk("R2 valid u_dut_nc", int'(ov1), int'(q1.size() != 0));
    if (ov0 && q0.size() != 0) cmp(g0, q0[0], 1'b0);
    if (ov1 && q1.size() != 0) cmp(g1, q1[0], 1'b1);
    in_valid = v; in_word = w; tstate = ts; out_ready = ordy;
    #1;
    chk("R2 ready", int'(rdy0), int'(q0.size() == 0 || ordy));
    chk("R2 ready nc", int'(rdy1), int'(q1.size() == 0 || ordy));
    if (ordy && q0.size() != 0) void'(q0.pop_front());
    if (ordy && q1.size() != 0) void'(q1.pop_front());
    if (v && rdy0) q0.push_back(model(w, ts, 1'b1));
    if (v && rdy1) q1.push_back(model(w, ts, 1'b0));
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R12 reset valid", int'(ov0 | ov1), 0);
    chk("R12 reset ready", int'(rdy0 & rdy1), 1);
    // every opcode, both option values, every thread state, back to back
    for (int op = 0; op < 32; op++)
      for (int ts = 0; ts < 4; ts++)
        for (int x = 0; x < 2; x++)
          step(1'b1, {4'($urandom), 1'(x), 4'($urandom), 5'($urandom), 8'($urandom), 5'(op)},
               2'(ts), 1'b1);
    // random stream with stalls and gaps
    for (int i = 0; i < 1500; i++)
      step(($urandom % 4) != 0, 27'($urandom), 2'($urandom), ($urandom % 3) != 0);
    // long stall holding one word, then drain
    step(1'b1, {4'hA, 1'b1, 4'h5, 5'h1F, 8'hC3, 5'd17}, 2'd1, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, 27'($urandom), 2'd2, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, '0, 2'd0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule